// File: doc/BRIEF.md
# Interrupt Latency Statistics Unit

This block times how long a device takes to answer an interrupt request. A one-cycle strobe marks the moment the request is raised. From that point the block counts coarse ticks, each a fixed number of clock cycles long, until it sees the device's response line go high. The response line is asynchronous and passes through a synchronizer first, so the synchronizer delay is part of every sample.

The block keeps the smallest and largest sample and a running sum. When a fixed power-of-two number of good samples has been collected, it raises `done` and reports the average, which is the sum shifted right by the base-two log of the series length. After that the results hold until software sends a clear. A sample whose response never comes is closed at the top of the timer range and counted as a timeout. A request strobe that arrives while a measurement is still running is ignored and sets a sticky overlap flag.

The default configuration has a 16-bit tick counter, 20 clock cycles per tick, a two-flop synchronizer and a series of 2^17 samples.

Top module: `irq_latency_stats`

## Requirements
- R1: If `irq_strobe` is sampled high at clock edge 0 while idle, and `resp_async` is first sampled high at edge d (d >= 1, after being low), the sample equals floor((d+1)/TICK_DIV) ticks. This holds with the default two synchronizer stages, as long as d+2 <= 2^TIMER_W * TICK_DIV.
- R2: Only a low-to-high transition of the synchronized response ends a measurement. A response that is already high when the strobe arrives does not end it.
- R3: If no response edge has been seen by edge 2^TIMER_W * TICK_DIV after the strobe, the measurement closes and `timeout_count` goes up by one, saturating at its maximum. `lat_min`, `lat_max` and `sample_count` do not change.
- R4: After each good sample, `lat_min` and `lat_max` hold the smallest and largest sample since the last clear, and `sample_count` goes up by one.
- R5: `lat_avg` is (sum of samples) >> LOG2_SAMPLES while `done` is high, and 0 otherwise.
- R6: `done` is high exactly when `sample_count` equals 2^LOG2_SAMPLES. While `done` is high, request strobes are ignored and all result outputs hold.
- R7: A `clear` pulse sets `lat_min` to all ones and sets `lat_max`, `sample_count`, `timeout_count`, `overlap` and `done` to zero. It also abandons any open measurement.
- R8: A strobe during an open measurement does not restart it, because timing continues from the first strobe. It sets `overlap`, which stays high until clear.
- R9: After reset the outputs take the same values that a clear gives.
- R10: A rising edge of the response while no measurement is open produces no sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_strobe | input | 1 | One-cycle pulse: interrupt request asserted, start timing |
| resp_async | input | 1 | Device response level, asynchronous |
| clear | input | 1 | Discard all results and start a new series |
| lat_min | output | TIMER_W | Smallest good sample in ticks |
| lat_max | output | TIMER_W | Largest good sample in ticks |
| lat_avg | output | TIMER_W | Series average in ticks, valid with done |
| sample_count | output | LOG2_SAMPLES+1 | Good samples collected |
| timeout_count | output | LOG2_SAMPLES+1 | Measurements closed without response |
| overlap | output | 1 | Sticky: a strobe arrived during an open measurement |
| done | output | 1 | Series complete, results frozen |

## Verification
The hardest cases to reach are the edges of the timer range. One is a response whose edge reaches the control logic on the same cycle as the final tick, which must still give the top value. The other is a response one cycle later, which must become a timeout. The bench uses a small configuration of 4-bit timer, 3 clocks per tick and 8-sample series. It sweeps the response delay cycle by cycle from 1 to 52, which walks through every tick boundary and both sides of the timeout edge, and it fills and clears several series along the way. A nested strobe, a response held high through the strobe and a response edge with nothing open are each set up with exact cycle placement.

// File: rtl/ils_pkg.sv
// ils_pkg: shared types for the interrupt latency statistics unit.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ils_pkg;
    typedef enum logic {
        MEAS_IDLE = 1'b0,
        MEAS_OPEN = 1'b1
    } meas_state_t;
endpackage

// File: rtl/ils_resp_sync.sv
// ils_resp_sync: brings the asynchronous response level into the clock
// domain through STAGES flops and flags its rising edge for one cycle.
// Assumes the response stays high or low for at least STAGES+1 cycles.
module ils_resp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic resp_async,
    output logic resp_rise
);
    logic [STAGES:0] pipe;

    // Shift the raw level through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], resp_async};
        end
    end

    // Rising edge seen at the synchronizer output.
    always_comb begin
        resp_rise = pipe[STAGES-1] & ~pipe[STAGES];
    end
endmodule

// File: rtl/ils_tick_gen.sv
// ils_tick_gen: divides the clock into coarse timing ticks while run is
// high. The phase returns to zero one cycle after run drops, so every
// measurement starts on a fresh tick phase.
// Assumes run is low for at least one cycle between measurements.
module ils_tick_gen #(
    parameter int TICK_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV == 1) begin : g_direct
            // A tick on every running cycle; no prescaler needed.
            always_comb begin
                tick = run;
            end
        end else begin : g_div
            localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);
            logic [PRE_W-1:0] phase;

            // Count clock cycles within the current tick.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    phase <= '0;
                end else if (phase == LAST) begin
                    phase <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end

            // Pulse on the final cycle of each tick period.
            always_comb begin
                tick = run && (phase == LAST);
            end
        end
    endgenerate
endmodule

// File: rtl/ils_meas_ctrl.sv
// ils_meas_ctrl: opens a measurement on a request strobe, counts ticks and
// closes on the first response edge or on timer exhaustion. It emits a
// one-cycle sample or timeout pulse and keeps the sticky overlap flag.
// Assumes irq_strobe is a single-cycle pulse; hold blocks new measurements.
module ils_meas_ctrl
    import ils_pkg::*;
#(
    parameter int TICK_DIV = 20,
    parameter int TIMER_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               irq_strobe,
    input  logic               resp_rise,
    input  logic               hold,
    output logic               smp_vld,
    output logic [TIMER_W-1:0] smp_val,
    output logic               tmo_vld,
    output logic               overlap
);
    meas_state_t        state;
    logic [TIMER_W-1:0] ticks;
    logic               tick;
    logic               running;

    // The tick divider runs only while a measurement is open.
    always_comb begin
        running = (state == MEAS_OPEN);
    end

    ils_tick_gen #(
        .TICK_DIV(TICK_DIV)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (running),
        .tick (tick)
    );

    // Measurement state machine with its tick counter and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= MEAS_IDLE;
            ticks   <= '0;
            smp_vld <= 1'b0;
            smp_val <= '0;
            tmo_vld <= 1'b0;
            overlap <= 1'b0;
        end else begin
            smp_vld <= 1'b0;
            tmo_vld <= 1'b0;
            if (clear) begin
                state   <= MEAS_IDLE;
                ticks   <= '0;
                overlap <= 1'b0;
            end else begin
                case (state)
                    MEAS_IDLE: begin
                        if (irq_strobe && !hold) begin
                            state <= MEAS_OPEN;
                            ticks <= '0;
                        end
                    end
                    MEAS_OPEN: begin
                        if (irq_strobe) begin
                            overlap <= 1'b1;
                        end
                        if (resp_rise) begin
                            smp_vld <= 1'b1;
                            smp_val <= ticks;
                            state   <= MEAS_IDLE;
                        end else if (tick) begin
                            if (&ticks) begin
                                tmo_vld <= 1'b1;
                                state   <= MEAS_IDLE;
                            end else begin
                                ticks <= ticks + 1'b1;
                            end
                        end
                    end
                    default: state <= MEAS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ils_stats_acc.sv
// ils_stats_acc: folds each good sample into min, max, sum and count, counts
// timeouts, and reports the average once the series is full.
// Assumes sample and timeout pulses are single-cycle and never coincide.
module ils_stats_acc #(
    parameter int TIMER_W = 16,
    parameter int LOG2_N  = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               smp_vld,
    input  logic [TIMER_W-1:0] smp_val,
    input  logic               tmo_vld,
    output logic [TIMER_W-1:0] lat_min,
    output logic [TIMER_W-1:0] lat_max,
    output logic [TIMER_W-1:0] lat_avg,
    output logic [LOG2_N:0]    sample_count,
    output logic [LOG2_N:0]    timeout_count,
    output logic               done
);
    localparam int SUM_W = TIMER_W + LOG2_N;
    localparam int CNT_W = LOG2_N + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << LOG2_N;

    logic [SUM_W-1:0] sum;

    // Series is complete when the good-sample count reaches its length.
    always_comb begin
        done = (sample_count == FULL);
    end

    // Accumulate statistics until the series is full or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lat_min       <= '1;
            lat_max       <= '0;
            sum           <= '0;
            sample_count  <= '0;
            timeout_count <= '0;
        end else if (!done) begin
            if (smp_vld) begin
                if (smp_val < lat_min) lat_min <= smp_val;
                if (smp_val > lat_max) lat_max <= smp_val;
                sum          <= sum + SUM_W'(smp_val);
                sample_count <= sample_count + 1'b1;
            end
            if (tmo_vld && !(&timeout_count)) begin
                timeout_count <= timeout_count + 1'b1;
            end
        end
    end

    // Average is the sum divided by the power-of-two series length.
    always_comb begin
        lat_avg = done ? TIMER_W'(sum >> LOG2_N) : '0;
    end
endmodule

// File: rtl/irq_latency_stats.sv
// irq_latency_stats: top of the interrupt latency statistics unit. It wires
// the response synchronizer, the measurement controller and the statistics
// accumulator together.
// Assumes irq_strobe is a one-cycle pulse in the clk domain.
module irq_latency_stats #(
    parameter int TICK_DIV     = 20,
    parameter int TIMER_W      = 16,
    parameter int LOG2_SAMPLES = 17,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    irq_strobe,
    input  logic                    resp_async,
    input  logic                    clear,
    output logic [TIMER_W-1:0]      lat_min,
    output logic [TIMER_W-1:0]      lat_max,
    output logic [TIMER_W-1:0]      lat_avg,
    output logic [LOG2_SAMPLES:0]   sample_count,
    output logic [LOG2_SAMPLES:0]   timeout_count,
    output logic                    overlap,
    output logic                    done
);
    logic               resp_rise;
    logic               smp_vld;
    logic [TIMER_W-1:0] smp_val;
    logic               tmo_vld;

    ils_resp_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .resp_async(resp_async),
        .resp_rise (resp_rise)
    );

    ils_meas_ctrl #(
        .TICK_DIV(TICK_DIV),
        .TIMER_W (TIMER_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .irq_strobe(irq_strobe),
        .resp_rise (resp_rise),
        .hold      (done),
        .smp_vld   (smp_vld),
        .smp_val   (smp_val),
        .tmo_vld   (tmo_vld),
        .overlap   (overlap)
    );

    ils_stats_acc #(
        .TIMER_W(TIMER_W),
        .LOG2_N (LOG2_SAMPLES)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear),
        .smp_vld      (smp_vld),
        .smp_val      (smp_val),
        .tmo_vld      (tmo_vld),
        .lat_min      (lat_min),
        .lat_max      (lat_max),
        .lat_avg      (lat_avg),
        .sample_count (sample_count),
        .timeout_count(timeout_count),
        .done         (done)
    );
endmodule

// File: rtl/ils_checker.sv
// ils_checker: temporal properties of the latency statistics unit, written
// against its ports and attached to every instance with bind.
// Assumes the synchronous active-low reset of the checked block.
module ils_checker #(
    parameter int TIMER_W      = 16,
    parameter int LOG2_SAMPLES = 17
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  irq_strobe,
    input logic                  clear,
    input logic [TIMER_W-1:0]    lat_min,
    input logic [TIMER_W-1:0]    lat_max,
    input logic [TIMER_W-1:0]    lat_avg,
    input logic [LOG2_SAMPLES:0] sample_count,
    input logic [LOG2_SAMPLES:0] timeout_count,
    input logic                  overlap,
    input logic                  done
);
    localparam logic [LOG2_SAMPLES:0] FULL = (LOG2_SAMPLES+1)'(1) << LOG2_SAMPLES;

    // R4: once any sample exists, the minimum never exceeds the maximum.
    assert_min_le_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_count != '0) |-> (lat_min <= lat_max));

    // R4: the sample count grows by at most one per cycle unless cleared.
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (sample_count == $past(sample_count)) ||
                   (sample_count == $past(sample_count) + 1'b1));

    // R3: the timeout count never drops unless cleared.
    assert_timeout_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (timeout_count >= $past(timeout_count)));

    // R5: a completed series has its average between min and max.
    assert_avg_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_avg >= lat_min) && (lat_avg <= lat_max));

    // R6: the count never passes the series length.
    assert_count_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_count <= FULL);

    // R6: results are frozen while the series is complete.
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> $stable(lat_min) && $stable(lat_max) &&
                             $stable(lat_avg) && $stable(sample_count) &&
                             $stable(timeout_count));

    // R7: a clear empties every result in the following cycle.
    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sample_count == '0) && (timeout_count == '0) &&
                  (lat_max == '0) && (&lat_min) && !overlap && !done);

    // R8: the overlap flag rises only after a request strobe.
    assert_overlap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overlap) |-> $past(irq_strobe));
endmodule

bind irq_latency_stats ils_checker #(
    .TIMER_W     (TIMER_W),
    .LOG2_SAMPLES(LOG2_SAMPLES)
) u_ils_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_strobe   (irq_strobe),
    .clear        (clear),
    .lat_min      (lat_min),
    .lat_max      (lat_max),
    .lat_avg      (lat_avg),
    .sample_count (sample_count),
    .timeout_count(timeout_count),
    .overlap      (overlap),
    .done         (done)
);

// File: tb/irq_latency_stats_bench.sv
// irq_latency_stats_bench: delay sweep over a small configuration with an
// arithmetic reference model in the bench.
module irq_latency_stats_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TD   = 3;
    localparam int TW   = 4;
    localparam int L2   = 3;
    localparam int NSER = 1 << L2;
    localparam int TMAX = (1 << TW) - 1;
    localparam int TLIM = (1 << TW) * TD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_strobe = 1'b0;
    logic          resp_async = 1'b0;
    logic          clear = 1'b0;
    logic [TW-1:0] lat_min, lat_max, lat_avg;
    logic [L2:0]   sample_count, timeout_count;
    logic          overlap, done;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cnt, m_min, m_max, m_sum, m_tmo;

    irq_latency_stats #(
        .TICK_DIV(TD), .TIMER_W(TW), .LOG2_SAMPLES(L2), .SYNC_STAGES(2)
    ) u_irq_latency_stats (
        .clk(clk), .rst_n(rst_n), .irq_strobe(irq_strobe),
        .resp_async(resp_async), .clear(clear),
        .lat_min(lat_min), .lat_max(lat_max), .lat_avg(lat_avg),
        .sample_count(sample_count), .timeout_count(timeout_count),
        .overlap(overlap), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_min = TMAX; m_max = 0; m_sum = 0; m_tmo = 0;
    endtask

    // Expected effect of one measurement with response first sampled at edge d.
    task automatic model_apply(input int d);
        int v;
        if (m_cnt == NSER) return;
        if (d + 2 > TLIM) begin
            if (m_tmo < (2 << L2) - 1) m_tmo++;
        end else begin
            v = (d + 1) / TD;
            m_cnt++;
            m_sum += v;
            if (v < m_min) m_min = v;
            if (v > m_max) m_max = v;
        end
    endtask

    task automatic check_all(input string tag);
        bit full;
        full = (m_cnt == NSER);
        chk({tag, " sample_count"}, int'(sample_count), m_cnt);
        chk({tag, " lat_min"}, int'(lat_min), m_min);
        chk({tag, " lat_max"}, int'(lat_max), m_max);
        chk({tag, " timeout_count"}, int'(timeout_count), m_tmo);
        chk({tag, " done R6"}, int'(done), int'(full));
        chk({tag, " lat_avg R5"}, int'(lat_avg), full ? (m_sum >> L2) : 0);
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_strobe = 1'b1;
        @(negedge clk); irq_strobe = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        @(negedge clk);
    endtask

    // Strobe, then raise the response so it is first sampled at edge d.
    task automatic measure(input int d);
        pulse_irq();
        repeat (d - 1) @(negedge clk);
        resp_async = 1'b1;
        repeat (60) @(negedge clk);
        resp_async = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 reset");
        chk("R9 overlap", int'(overlap), 0);

        // R1 R3 R4: cycle-by-cycle delay sweep across tick and timeout edges.
        for (int d = 1; d <= 52; d++) begin
            measure(d);
            model_apply(d);
            check_all("R1 sweep");
            if (m_cnt == NSER) begin
                measure(5);               // R6: ignored while complete
                model_apply(5);
                check_all("R6 hold");
                chk("R6 overlap", int'(overlap), 0);
                pulse_clear();
                model_reset();
                check_all("R7 clear");
            end
        end

        // R10: a response edge with nothing open yields no sample.
        pulse_clear();
        model_reset();
        @(negedge clk); resp_async = 1'b1;
        repeat (10) @(negedge clk); resp_async = 1'b0;
        repeat (5) @(negedge clk);
        check_all("R10 idle edge");

        // R8: a second strobe mid-measurement keeps the first start time.
        pulse_irq();
        repeat (4) @(negedge clk);
        irq_strobe = 1'b1;
        @(negedge clk); irq_strobe = 1'b0;
        repeat (14) @(negedge clk);
        resp_async = 1'b1;
        repeat (60) @(negedge clk);
        resp_async = 1'b0;
        repeat (4) @(negedge clk);
        model_apply(20);
        check_all("R8 nested");
        chk("R8 overlap set", int'(overlap), 1);
        pulse_clear();
        model_reset();
        chk("R7 overlap cleared", int'(overlap), 0);

        // R2: a response already high at the strobe does not close it.
        resp_async = 1'b1;
        repeat (5) @(negedge clk);
        pulse_irq();
        repeat (10) @(negedge clk);
        chk("R2 level ignored", int'(sample_count), 0);
        resp_async = 1'b0;
        repeat (3) @(negedge clk);
        resp_async = 1'b1;
        repeat (60) @(negedge clk);
        resp_async = 1'b0;
        repeat (4) @(negedge clk);
        model_apply(14);
        check_all("R2 fresh edge");
        chk("R2 value", int'(lat_max), 5);

        // R7: clear while a measurement is open abandons it.
        pulse_irq();
        repeat (3) @(negedge clk);
        pulse_clear();
        model_reset();
        resp_async = 1'b1;
        repeat (10) @(negedge clk);
        resp_async = 1'b0;
        repeat (4) @(negedge clk);
        check_all("R7 abandon");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule